// File: doc/BRIEF.md
# I2S Slave Receiver

This block receives a two-channel serial audio stream in slave mode. An external source supplies the bit clock, the word strobe and the serial data line. The block samples all three lines with its own fast system clock, passes them through two synchronizing flops, finds the rising edges of the bit clock, and captures one data bit at each of those edges, most significant bit first.

Three static configuration inputs shape the framing. The first selects a 16-bit or a 32-bit channel slot. The second selects standard I2S framing, where the first bit of a slot follows the strobe change by one bit clock, or left-justified framing, where the first bit coincides with the strobe change. The third selects which strobe level marks the left channel. Each completed left/right pair is presented as two 24-bit samples with a one-cycle valid pulse. Frame rates from 6.4 kHz to 48 kHz are accepted, including 64 bit clocks per 48 kHz frame (about 3.07 MHz), as long as the system clock is several times faster than the bit clock.

The configuration inputs are expected to change only while the block is held in reset.

Top module: `i2s_slave_rx`

## Requirements
- R1: While reset is asserted, and after its release until the first pair completes, `pair_valid_o` is 0 and `left_o` and `right_o` are all zeros.
- R2: A data bit is taken at each rising edge of `ser_clk_i`, together with the strobe level at that edge. All three serial lines pass two synchronizing flops. The outputs and the valid pulse for a completed pair change on the second system-clock edge after the first edge that samples `ser_clk_i` high for the final bit of the right slot.
- R3: With `cfg_wide_i` = 1, a slot holds 32 bits. The first 24 bits received form the sample (first bit in bit 23). The remaining 8 bits of the slot are ignored.
- R4: With `cfg_wide_i` = 0, a slot holds 16 bits. They appear in bits 23..8 (first bit in bit 23), and bits 7..0 are 0. Any bits after the 16th, up to the next slot boundary, are ignored.
- R5: With `cfg_delay_i` = 1, a slot starts at the rising edge after the one at which the strobe first shows its new level. The bit taken at that first edge still belongs to the previous slot. With `cfg_delay_i` = 0, the bit taken at that first edge is the first bit of the new slot.
- R6: A strobe level equal to `cfg_left_lvl_i` marks the left channel, and the opposite level marks the right channel.
- R7: `pair_valid_o` pulses for exactly one cycle, only when a right slot completes after a completed left slot. A right slot with no completed left slot before it produces no pulse. A slot boundary is recognised only after two earlier bit-clock rising edges since reset, so a slot already in progress at reset is discarded.
- R8: Between pulses, `left_o` and `right_o` hold the last delivered pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | External serial bit clock |
| ser_ws_i | input | 1 | External word strobe (channel select) |
| ser_dat_i | input | 1 | External serial data |
| cfg_wide_i | input | 1 | 1: 32-bit slots, 0: 16-bit slots |
| cfg_delay_i | input | 1 | 1: one-bit delay after the strobe change (standard I2S), 0: left-justified |
| cfg_left_lvl_i | input | 1 | Strobe level that marks the left channel |
| left_o | output | 24 | Left sample of the last completed pair |
| right_o | output | 24 | Right sample of the last completed pair |
| pair_valid_o | output | 1 | One-cycle pulse when a new pair is presented |

## Verification
A pair is due on the second system-clock edge after the first edge that samples the final right-slot bit clock high. Every other output must stay unchanged in every cycle. The bench drives the serial lines only on falling system-clock edges. A behavioural model applies each observed bit-clock rise two edges after it samples it, and the bench compares valid and both samples against that model on every falling edge. Each valid pulse is also matched against a queue of the words the bench framed and sent. So a pulse one cycle early or late, a shifted bit, a wrong framing delay or polarity, or a lost or extra frame each shows up as a failed comparison.

// File: rtl/i2s_rx_pkg.sv
`timescale 1ns/1ps
package i2s_rx_pkg;
  localparam int SLOT_MAX_BITS = 32;
  localparam int SAMPLE_BITS   = 24;
  localparam int SYNC_DEPTH    = 2;

  typedef struct packed {
    logic sck;
    logic ws;
    logic sd;
  } ser_lines_t;

  localparam int LINE_BITS = $bits(ser_lines_t);
endpackage

// File: rtl/i2s_rx_sync.sv
`timescale 1ns/1ps
module i2s_rx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb chain_d = {chain_q[STAGES-2:0], d_i[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign q_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/i2s_rx_edge.sv
`timescale 1ns/1ps
module i2s_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sck_i;
  end

  assign rise_o = sck_i & ~prev_q;

  // R2: a bit-clock rise is reported for a single system cycle
  p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/i2s_rx_deframer.sv
`timescale 1ns/1ps
module i2s_rx_deframer #(
  parameter int SLOT_MAX = 32,
  parameter int OUT_W    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             ws_i,
  input  logic             sd_i,
  input  logic             cfg_wide_i,
  input  logic             cfg_delay_i,
  input  logic             cfg_left_lvl_i,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o
);
  localparam int CNT_W  = $clog2(SLOT_MAX) + 1;
  localparam int HALF   = SLOT_MAX / 2;
  localparam int PAD_W  = OUT_W - HALF;

  logic [1:0]          prime_q, prime_d;
  logic                ws_prev_q, ws_prev_d;
  logic                eff_prev_q, eff_prev_d;
  logic                busy_q, busy_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                ch_q, ch_d;
  logic [SLOT_MAX-1:0] shreg_q, shreg_d;
  logic                got_left_q, got_left_d;
  logic [OUT_W-1:0]    hold_q, hold_d;
  logic [OUT_W-1:0]    left_q, left_d;
  logic [OUT_W-1:0]    right_q, right_d;
  logic                valid_q, valid_d;

  logic                ws_is_left;
  logic                eff_left;
  logic                boundary;
  logic [SLOT_MAX-1:0] shifted;
  logic [CNT_W-1:0]    slot_bits;
  logic [CNT_W-1:0]    cnt_inc;
  logic [OUT_W-1:0]    word;

  always_comb begin
    ws_is_left = (ws_i == cfg_left_lvl_i);
    eff_left   = cfg_delay_i ? ws_prev_q : ws_is_left;
    boundary   = (prime_q == 2'd2) && (eff_left != eff_prev_q);
    shifted    = {shreg_q[SLOT_MAX-2:0], sd_i};
    slot_bits  = cfg_wide_i ? CNT_W'(SLOT_MAX) : CNT_W'(HALF);
    cnt_inc    = cnt_q + CNT_W'(1);
    word       = cfg_wide_i ? shifted[SLOT_MAX-1 -: OUT_W]
                            : {shifted[HALF-1:0], {PAD_W{1'b0}}};
  end

  always_comb begin
    prime_d    = prime_q;
    ws_prev_d  = ws_prev_q;
    eff_prev_d = eff_prev_q;
    busy_d     = busy_q;
    cnt_d      = cnt_q;
    ch_d       = ch_q;
    shreg_d    = shreg_q;
    got_left_d = got_left_q;
    hold_d     = hold_q;
    left_d     = left_q;
    right_d    = right_q;
    valid_d    = 1'b0;
    if (rise_i) begin
      if (prime_q != 2'd2) prime_d = prime_q + 2'd1;
      ws_prev_d  = ws_is_left;
      eff_prev_d = eff_left;
      if (boundary) begin
        busy_d  = 1'b1;
        cnt_d   = CNT_W'(1);
        ch_d    = eff_left;
        shreg_d = {{(SLOT_MAX-1){1'b0}}, sd_i};
      end else if (busy_q) begin
        shreg_d = shifted;
        cnt_d   = cnt_inc;
        if (cnt_inc == slot_bits) begin
          busy_d = 1'b0;
          if (ch_q) begin
            hold_d     = word;
            got_left_d = 1'b1;
          end else if (got_left_q) begin
            left_d     = hold_q;
            right_d    = word;
            valid_d    = 1'b1;
            got_left_d = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prime_q    <= '0;
      ws_prev_q  <= 1'b0;
      eff_prev_q <= 1'b0;
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      ch_q       <= 1'b0;
      shreg_q    <= '0;
      got_left_q <= 1'b0;
      hold_q     <= '0;
      left_q     <= '0;
      right_q    <= '0;
      valid_q    <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (rise_i) begin
        prime_q    <= prime_d;
        ws_prev_q  <= ws_prev_d;
        eff_prev_q <= eff_prev_d;
        busy_q     <= busy_d;
        cnt_q      <= cnt_d;
        ch_q       <= ch_d;
        shreg_q    <= shreg_d;
        got_left_q <= got_left_d;
        hold_q     <= hold_d;
        left_q     <= left_d;
        right_q    <= right_d;
      end
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;

  // R7: one pulse per completed pair, never two cycles in a row
  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R2: a pulse only follows a detected bit-clock rise
  p_valid_after_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(rise_i));
  // R8: samples hold between pulses
  p_hold_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> ($stable(left_q) && $stable(right_q)));
  // R4: narrow samples carry zero padding in the low bits
  p_narrow_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !cfg_wide_i) |-> (left_q[PAD_W-1:0] == '0 && right_q[PAD_W-1:0] == '0));
  // R3: a running slot never counts past the selected width
  p_cnt_in_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0 && cnt_q < slot_bits));
endmodule

// File: rtl/i2s_slave_rx.sv
`timescale 1ns/1ps
module i2s_slave_rx
  import i2s_rx_pkg::*;
#(
  parameter int SLOT_MAX = SLOT_MAX_BITS,
  parameter int OUT_W    = SAMPLE_BITS,
  parameter int SYNC_N   = SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk_i,
  input  logic             ser_ws_i,
  input  logic             ser_dat_i,
  input  logic             cfg_wide_i,
  input  logic             cfg_delay_i,
  input  logic             cfg_left_lvl_i,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             pair_valid_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ser_lines_t raw_lines;
  ser_lines_t sync_lines;
  logic       sck_rise;

  assign raw_lines = '{sck: ser_clk_i, ws: ser_ws_i, sd: ser_dat_i};

  i2s_rx_sync #(.W(LINE_BITS), .STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (raw_lines),
    .q_o   (sync_lines)
  );

  i2s_rx_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sck_i  (sync_lines.sck),
    .rise_o (sck_rise)
  );

  i2s_rx_deframer #(.SLOT_MAX(SLOT_MAX), .OUT_W(OUT_W)) u_deframer (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .rise_i         (sck_rise),
    .ws_i           (sync_lines.ws),
    .sd_i           (sync_lines.sd),
    .cfg_wide_i     (cfg_wide_i),
    .cfg_delay_i    (cfg_delay_i),
    .cfg_left_lvl_i (cfg_left_lvl_i),
    .left_o         (left_o),
    .right_o        (right_o),
    .valid_o        (pair_valid_o)
  );

  // R1: no pulse while the internal reset is still held
  p_quiet_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_int_n |=> !pair_valid_o);
endmodule

// File: tb/test_i2s_slave_rx.sv
`timescale 1ns/1ps
module test_i2s_slave_rx;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        sck, ws, sd;
  logic        cfg_wide, cfg_delay, cfg_lvl;
  logic [23:0] lo, ro;
  logic        vo;

  i2s_slave_rx i_i2s_slave_rx (
    .clk(clk), .rst_n(rst_n),
    .ser_clk_i(sck), .ser_ws_i(ws), .ser_dat_i(sd),
    .cfg_wide_i(cfg_wide), .cfg_delay_i(cfg_delay), .cfg_left_lvl_i(cfg_lvl),
    .left_o(lo), .right_o(ro), .pair_valid_o(vo)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string grp_tag = "R3";

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [2:0]    h [4];           // {sck, ws, sd} sampled on recent edges
  int          m_n;
  bit          m_ws_last, m_eff_last, m_busy, m_ch, m_got_left, m_valid;
  int          m_cnt;
  logic [31:0] m_val;
  logic [23:0] m_hold, m_left, m_right;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) h[i] = '0;
      m_n = 0; m_ws_last = 0; m_eff_last = 0; m_busy = 0; m_ch = 0;
      m_got_left = 0; m_valid = 0; m_cnt = 0; m_val = '0;
      m_hold = '0; m_left = '0; m_right = '0;
    end else begin
      h[3] = h[2]; h[2] = h[1]; h[1] = h[0]; h[0] = {sck, ws, sd};
      m_valid = 0;
      if (h[2][2] && !h[3][2]) begin
        bit wl, eff, bit_in;
        int width;
        logic [23:0] smp;
        wl     = (h[2][1] == cfg_lvl);
        bit_in = h[2][0];
        eff    = cfg_delay ? m_ws_last : wl;
        width  = cfg_wide ? 32 : 16;
        if (m_n >= 2 && eff != m_eff_last) begin
          m_busy = 1; m_cnt = 1; m_val = {31'd0, bit_in}; m_ch = eff;
        end else if (m_busy) begin
          m_val = {m_val[30:0], bit_in};
          m_cnt++;
          if (m_cnt == width) begin
            m_busy = 0;
            smp = (width == 32) ? m_val[31:8] : {m_val[15:0], 8'h00};
            if (m_ch) begin
              m_hold = smp; m_got_left = 1;
            end else if (m_got_left) begin
              m_left = m_hold; m_right = smp; m_valid = 1; m_got_left = 0;
            end
          end
        end
        m_ws_last = wl; m_eff_last = eff;
        if (m_n < 2) m_n++;
      end
    end
  end

  // ---------------- expected-frame queue ----------------
  logic [47:0] exp_q [$];
  bit          q_ch [$];
  bit          q_d  [$];

  function automatic logic [23:0] exp_smp(input logic [31:0] w, input bit wide);
    return wide ? w[31:8] : {w[31:16], 8'h00};
  endfunction

  function automatic logic [31:0] pat(input int i);
    return 32'hA5C3_0F81 ^ (32'(i) * 32'h1357_9BDF);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk(vo == m_valid, "R7", "valid vs model", {31'd0, vo}, {31'd0, m_valid});
      chk(lo == m_left,  m_valid ? "R2" : "R8", "left vs model",  {8'd0, lo}, {8'd0, m_left});
      chk(ro == m_right, m_valid ? "R2" : "R8", "right vs model", {8'd0, ro}, {8'd0, m_right});
      if (vo) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7", "pulse with no frame sent", {31'd0, vo}, 32'd0);
        end else begin
          logic [47:0] pr;
          pr = exp_q.pop_front();
          chk(lo == pr[47:24], grp_tag, "left sample",  {8'd0, lo}, {8'd0, pr[47:24]});
          chk(ro == pr[23:0],  grp_tag, "right sample", {8'd0, ro}, {8'd0, pr[23:0]});
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic send_bit(input logic w, input logic d);
    @(negedge clk); sck = 1'b0; ws = w; sd = d;
    repeat (3) @(negedge clk);
    sck = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic push_slot(input bit ch, input logic [31:0] w, input int len);
    for (int i = 0; i < len; i++) begin
      q_ch.push_back(ch);
      q_d.push_back(i < 32 ? w[31-i] : 1'b0);
    end
  endtask

  task automatic push_frame(input logic [31:0] l, input logic [31:0] r,
                            input int len, input bit expect_pair);
    push_slot(1'b1, l, len);
    push_slot(1'b0, r, len);
    if (expect_pair) exp_q.push_back({exp_smp(l, cfg_wide), exp_smp(r, cfg_wide)});
  endtask

  task automatic drive_stream();
    int nb;
    nb = q_ch.size();
    for (int i = 0; i < nb; i++) begin
      bit chd;
      chd = (cfg_delay && (i + 1 < nb)) ? q_ch[i+1] : q_ch[i];
      send_bit(chd ? cfg_lvl : ~cfg_lvl, q_d[i]);
    end
    @(negedge clk); sck = 1'b0;
    q_ch.delete(); q_d.delete();
  endtask

  task automatic do_reset(input bit wide, input bit dly, input bit lvl);
    @(negedge clk);
    rst_n = 1'b0; sck = 1'b0; ws = 1'b0; sd = 1'b0;
    cfg_wide = wide; cfg_delay = dly; cfg_lvl = lvl;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(vo == 1'b0, "R1", "valid in reset", {31'd0, vo}, 32'd0);
    chk(lo == '0,   "R1", "left in reset",  {8'd0, lo}, 32'd0);
    chk(ro == '0,   "R1", "right in reset", {8'd0, ro}, 32'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(vo == 1'b0 && lo == '0, "R1", "state after release", {8'd0, lo}, 32'd0);
  endtask

  task automatic run_group(input bit wide, input bit dly, input bit lvl,
                           input int len, input int frames, input int seed, input string tag);
    grp_tag = tag;
    do_reset(wide, dly, lvl);
    push_slot(1'b0, 32'h0, 3);
    for (int f = 0; f < frames; f++)
      push_frame(pat(seed + 2*f), pat(seed + 2*f + 1), len, 1'b1);
    push_slot(1'b1, 32'h0, 2);
    drive_stream();
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "frames not delivered", exp_q.size(), 32'd0);
    exp_q.delete();
  endtask

  initial begin
    rst_n = 1'b0; sck = 1'b0; ws = 1'b0; sd = 1'b0;
    cfg_wide = 1'b1; cfg_delay = 1'b1; cfg_lvl = 1'b0;
    // R3 wide slots, R5 standard delay, left on strobe low
    run_group(1'b1, 1'b1, 1'b0, 32, 3, 1,  "R3");
    // R4 narrow 16-bit slots
    run_group(1'b0, 1'b1, 1'b0, 16, 3, 11, "R4");
    // R5 left-justified, R4 extra bits ignored in 32-clock slots, R6 left on high
    run_group(1'b0, 1'b0, 1'b1, 32, 2, 21, "R5");
    // R6 wide, left on strobe high, no delay
    run_group(1'b1, 1'b0, 1'b1, 32, 2, 31, "R6");
    // R7 partial left slot then right slot: no pulse; then a full frame
    grp_tag = "R7";
    do_reset(1'b1, 1'b1, 1'b1);
    push_slot(1'b1, pat(41), 10);
    push_slot(1'b0, pat(42), 32);
    push_frame(pat(43), pat(44), 32, 1'b1);
    push_slot(1'b1, 32'h0, 2);
    drive_stream();
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "frame after partial not delivered", exp_q.size(), 32'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R7 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule